// File: doc/BRIEF.md
# Three-Input Bitwise Lookup Logic Unit

This unit computes an arbitrary bitwise function of three wide operands. An 8-bit immediate serves as a truth table: for every bit position, the three operand bits at that position form a 3-bit index, and the immediate bit at that index becomes the raw result bit. Any of the 256 possible three-input boolean functions can be produced this way, including AND, OR, XOR, majority and bitwise select.

The raw result is then written under a per-lane mask. Lanes are 32 or 64 bits wide. Lanes whose mask bit is clear are either forced to zero or keep the corresponding bits of a supplied previous destination value. A global enable can switch masking off so that every bit is written. The result is registered, and a valid strobe follows the input strobe by one cycle.

Top module: `tern_logic_unit`

## Requirements
- R1: Each raw result bit equals `imm[{op_a[i], op_b[i], op_c[i]}]`, with op_a as the most significant index bit. All three operand bits set selects imm bit 7, and all clear selects imm bit 0.
- R2: With masking off, imm 0x80 yields `op_a & op_b & op_c`, imm 0xFE yields `op_a | op_b | op_c`, and imm 0xCA yields op_b where op_a is 1 and op_c where op_a is 0.
- R3: out_valid is high in the cycle after a cycle with in_valid high, and low after a cycle with in_valid low.
- R4: After reset, out_valid is 0 and result is all zeros.
- R5: With mask_on = 0, every bit of result takes the raw lookup value, whatever mask, zero_mode and old_dst hold.
- R6: With lane_wide = 0 and mask_on = 1, mask bit i controls result bits 32i+31 down to 32i.
- R7: With lane_wide = 1 and mask_on = 1, mask bit i controls result bits 64i+63 down to 64i. The upper half of mask has no effect.
- R8: With zero_mode = 1, the bits of unselected lanes are 0.
- R9: With zero_mode = 0, the bits of unselected lanes equal old_dst.
- R10: In a cycle with in_valid low, result keeps the value it had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| op_a | input | DATA_W | Operand giving index bit 2 |
| op_b | input | DATA_W | Operand giving index bit 1 |
| op_c | input | DATA_W | Operand giving index bit 0 |
| imm | input | 8 | Truth table |
| mask | input | DATA_W/32 | Lane select bits |
| mask_on | input | 1 | 1 applies the mask, 0 writes all lanes |
| lane_wide | input | 1 | 0 selects 32-bit lanes, 1 selects 64-bit lanes |
| zero_mode | input | 1 | 1 zeroes unselected lanes, 0 keeps old_dst in them |
| old_dst | input | DATA_W | Previous destination value for merging |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | DATA_W | Registered masked result |

## Verification
The properties assume every control input is a defined 0 or 1 whenever in_valid is high, and that DATA_W is a multiple of 64. They probe the lowest lane and the all-zero and all-one truth tables, so they rely on the merge and lane decode treating lane 0 like any other lane. The stimulus drives every control from known values on the falling edge, with random operands, immediates, masks and modes. It also holds in_valid low for some cycles so that the hold behaviour is exercised between requests.

// File: rtl/tlu_pkg.sv
// Shared definitions for the three-input bitwise lookup logic unit.
// Assumes the data path width is a multiple of the widest lane.
package tlu_pkg;
    localparam int unsigned CHUNK_W  = 32;
    localparam int unsigned WIDE_W   = 64;
    localparam int unsigned TABLE_W  = 8;

    typedef enum logic {
        LANE_NARROW = 1'b0,
        LANE_BROAD  = 1'b1
    } lane_size_e;

    typedef enum logic {
        FILL_KEEP = 1'b0,
        FILL_ZERO = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/tlu_bit_lut.sv
// Per-bit truth-table lookup: each output bit picks one immediate bit,
// indexed by the three operand bits at that position (a is the MSB).
// Purely combinational; assumes W >= 1.
module tlu_bit_lut
    import tlu_pkg::*;
#(
    parameter int unsigned W = 512
) (
    input  logic [W-1:0]       src_a,
    input  logic [W-1:0]       src_b,
    input  logic [W-1:0]       src_c,
    input  logic [TABLE_W-1:0] table_bits,
    output logic [W-1:0]       raw_out
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic [2:0] sel_idx;
            // Form the lookup index for this bit position.
            assign sel_idx    = {src_a[gi], src_b[gi], src_c[gi]};
            // Select the truth-table entry.
            assign raw_out[gi] = table_bits[sel_idx];
        end
    endgenerate
endmodule

// File: rtl/tlu_lane_expand.sv
// Converts the lane mask into one write enable per 32-bit chunk.
// In wide mode a mask bit covers two neighbouring chunks; the upper half
// of the mask is then unused. Assumes NCHUNK is even.
module tlu_lane_expand
    import tlu_pkg::*;
#(
    parameter int unsigned NCHUNK = 16
) (
    input  logic [NCHUNK-1:0] lane_mask,
    input  logic              mask_on,
    input  lane_size_e        lane_size,
    output logic [NCHUNK-1:0] chunk_en
);
    localparam int unsigned PER_WIDE = WIDE_W / CHUNK_W;

    genvar gj;
    generate
        for (gj = 0; gj < NCHUNK; gj++) begin : g_chunk
            logic sel_bit;
            // Pick the mask bit that owns this chunk at the chosen lane size.
            assign sel_bit = (lane_size == LANE_BROAD) ? lane_mask[gj / PER_WIDE]
                                                       : lane_mask[gj];
            // Masking off writes every chunk.
            assign chunk_en[gj] = !mask_on || sel_bit;
        end
    endgenerate
endmodule

// File: rtl/tlu_merge.sv
// Applies chunk enables to the raw lookup result: enabled chunks pass,
// disabled chunks become zero or take the previous destination bits.
// Combinational; assumes W == NCHUNK * CHUNK_W.
module tlu_merge
    import tlu_pkg::*;
#(
    parameter int unsigned W      = 512,
    parameter int unsigned NCHUNK = W / CHUNK_W
) (
    input  logic [W-1:0]      raw_in,
    input  logic [W-1:0]      prev_dst,
    input  logic [NCHUNK-1:0] chunk_en,
    input  fill_mode_e        fill_mode,
    output logic [W-1:0]      merged
);
    genvar gk;
    generate
        for (gk = 0; gk < NCHUNK; gk++) begin : g_merge
            logic [CHUNK_W-1:0] fill_val;
            // Value used when this chunk is not written.
            assign fill_val = (fill_mode == FILL_ZERO) ? '0
                                : prev_dst[gk*CHUNK_W +: CHUNK_W];
            // Choose computed or fill data.
            assign merged[gk*CHUNK_W +: CHUNK_W] =
                chunk_en[gk] ? raw_in[gk*CHUNK_W +: CHUNK_W] : fill_val;
        end
    endgenerate
endmodule

// File: rtl/tern_logic_unit.sv
// Three-input bitwise lookup logic unit with lane-masked, registered output.
// One request per cycle, one-cycle latency, no back-pressure.
// Assumes DATA_W is a multiple of 64. Reset is synchronous, active low.
module tern_logic_unit
    import tlu_pkg::*;
#(
    parameter int unsigned DATA_W = 512,
    localparam int unsigned MASK_W = DATA_W / CHUNK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic [7:0]        imm,
    input  logic [MASK_W-1:0] mask,
    input  logic              mask_on,
    input  logic              lane_wide,
    input  logic              zero_mode,
    input  logic [DATA_W-1:0] old_dst,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] raw_bits;
    logic [DATA_W-1:0] masked_bits;
    logic [MASK_W-1:0] chunk_en;
    lane_size_e        lane_size;
    fill_mode_e        fill_mode;

    // Map plain control pins onto the shared enum types.
    assign lane_size = lane_size_e'(lane_wide);
    assign fill_mode = fill_mode_e'(zero_mode);

    tlu_bit_lut #(.W(DATA_W)) u_lut (
        .src_a      (op_a),
        .src_b      (op_b),
        .src_c      (op_c),
        .table_bits (imm),
        .raw_out    (raw_bits)
    );

    tlu_lane_expand #(.NCHUNK(MASK_W)) u_expand (
        .lane_mask (mask),
        .mask_on   (mask_on),
        .lane_size (lane_size),
        .chunk_en  (chunk_en)
    );

    tlu_merge #(.W(DATA_W), .NCHUNK(MASK_W)) u_merge (
        .raw_in    (raw_bits),
        .prev_dst  (old_dst),
        .chunk_en  (chunk_en),
        .fill_mode (fill_mode),
        .merged    (masked_bits)
    );

    // Valid strobe follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the masked result on a request, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= masked_bits;
    end
endmodule

// File: rtl/tlu_checker.sv
// Protocol and lane-0 behaviour properties for tern_logic_unit.
// Assumes controls are defined whenever in_valid is high.
module tlu_checker #(
    parameter int unsigned DATA_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [7:0]        imm,
    input logic              sel0,
    input logic              mask_on,
    input logic              lane_wide,
    input logic              zero_mode,
    input logic [31:0]       old_lo,
    input logic [DATA_W-1:0] result
);
    // R3: strobe follows request
    assert_valid_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10: idle cycles hold the result
    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R1 / R5: constant truth tables with masking off
    assert_all_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_on && imm == 8'hFF) |=> (&result));
    assert_all_zeros_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_on && imm == 8'h00) |=> (result == '0));
    // R8: zeroed narrow lane 0
    assert_zero_lane0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_on && !sel0 && zero_mode && !lane_wide)
        |=> (result[31:0] == 32'h0));
    // R9: merged narrow lane 0 keeps old destination
    assert_merge_lane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_on && !sel0 && !zero_mode && !lane_wide)
        |=> (result[31:0] == $past(old_lo)));
    // R7: wide lane 0 zeroed as a whole
    assert_wide_lane0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_on && !sel0 && zero_mode && lane_wide)
        |=> (result[63:0] == 64'h0));
endmodule

bind tern_logic_unit tlu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .imm       (imm),
    .sel0      (mask[0]),
    .mask_on   (mask_on),
    .lane_wide (lane_wide),
    .zero_mode (zero_mode),
    .old_lo    (old_dst[31:0]),
    .result    (result)
);

// File: tb/tern_logic_unit_test.sv
module tern_logic_unit_test;
    localparam int W  = 512;
    localparam int MW = W / 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [W-1:0]  op_a, op_b, op_c, old_dst;
    logic [7:0]    imm;
    logic [MW-1:0] mask;
    logic          mask_on, lane_wide, zero_mode;
    logic          out_valid;
    logic [W-1:0]  result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tern_logic_unit #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .imm(imm),
        .mask(mask), .mask_on(mask_on), .lane_wide(lane_wide),
        .zero_mode(zero_mode), .old_dst(old_dst),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [W-1:0] model(
        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
        input logic [7:0] t, input logic [MW-1:0] m, input logic on,
        input logic wide, input logic zf, input logic [W-1:0] old);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            logic bitv;
            logic en;
            int   lane;
            bitv = t[{a[i], b[i], c[i]}];
            lane = wide ? (i / 64) : (i / 32);
            en   = !on || m[lane];
            r[i] = en ? bitv : (zf ? 1'b0 : old[i]);
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [W-1:0] got,
                             input logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s result=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    // Drive one request at the falling edge, check after the capturing edge.
    task automatic run_op(input string req, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [W-1:0] c,
                          input logic [7:0] t, input logic [MW-1:0] m,
                          input logic on, input logic wide, input logic zf,
                          input logic [W-1:0] old);
        logic [W-1:0] exp;
        exp = model(a, b, c, t, m, on, wide, zf, old);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; op_c = c; imm = t;
        mask = m; mask_on = on; lane_wide = wide; zero_mode = zf; old_dst = old;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({req, " out_valid R3"}, out_valid, 1'b1);
        check_vec(req, result, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a, b, c, o, held;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; op_c = '0;
        imm = '0; mask = '0; mask_on = 1'b0; lane_wide = 1'b0;
        zero_mode = 1'b0; old_dst = '0;
        repeat (3) @(negedge clk);
        // R4: reset state
        check_bit("R4 out_valid", out_valid, 1'b0);
        check_vec("R4 result", result, '0);
        rst_n = 1'b1;

        a = rnd_vec(); b = rnd_vec(); c = rnd_vec(); o = rnd_vec();
        // R2: named functions with masking off
        run_op("R2 and", a, b, c, 8'h80, '0, 1'b0, 1'b0, 1'b1, o);
        check_vec("R2 and direct", result, a & b & c);
        run_op("R2 or", a, b, c, 8'hFE, '0, 1'b0, 1'b0, 1'b1, o);
        check_vec("R2 or direct", result, a | b | c);
        run_op("R2 select", a, b, c, 8'hCA, '0, 1'b0, 1'b0, 1'b1, o);
        check_vec("R2 select direct", result, (a & b) | (~a & c));

        // R1: each single table entry chosen only by its index
        for (int k = 0; k < 8; k++)
            run_op("R1 single entry", a, b, c, 8'(1 << k), '0, 1'b0, 1'b0, 1'b0, o);
        run_op("R1 index 7", '1, '1, '1, 8'h80, '0, 1'b0, 1'b0, 1'b0, o);
        check_vec("R1 index 7 direct", result, '1);

        // R5: masking off ignores mask, mode and old_dst
        run_op("R5 mask off", a, b, c, 8'h96, '0, 1'b0, 1'b1, 1'b0, o);
        check_vec("R5 direct", result, a ^ b ^ c);

        // R6 / R8: narrow lanes, alternating mask, zeroing
        run_op("R6 R8 narrow zero", a, b, c, 8'hE8, 16'h5555, 1'b1, 1'b0, 1'b1, o);
        // R6 / R9: narrow lanes, merging
        run_op("R6 R9 narrow merge", a, b, c, 8'hE8, 16'hA00F, 1'b1, 1'b0, 1'b0, o);
        // R7: wide lanes; upper mask half must have no effect
        run_op("R7 wide zero", a, b, c, 8'h3C, 16'hFF5A, 1'b1, 1'b1, 1'b1, o);
        check_vec("R7 upper half ignored", result,
                  model(a, b, c, 8'h3C, 16'h005A, 1'b1, 1'b1, 1'b1, o));
        run_op("R7 R9 wide merge", a, b, c, 8'h3C, 16'h0081, 1'b1, 1'b1, 1'b0, o);
        // R8 / R9 all lanes off
        run_op("R8 all off", a, b, c, 8'hFF, '0, 1'b1, 1'b0, 1'b1, o);
        run_op("R9 all off", a, b, c, 8'hFF, '0, 1'b1, 1'b1, 1'b0, o);

        // R10 / R3: idle cycles keep result, valid drops
        held = result;
        @(negedge clk);
        op_a = rnd_vec(); op_b = rnd_vec(); imm = 8'h5A; old_dst = rnd_vec();
        @(negedge clk);
        check_bit("R3 idle out_valid", out_valid, 1'b0);
        check_vec("R10 hold", result, held);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] ctl;
            ctl = $urandom;
            run_op("R1 R6 R7 R8 R9 random", rnd_vec(), rnd_vec(), rnd_vec(),
                   ctl[7:0], ctl[23:8], ctl[24], ctl[25], ctl[26], rnd_vec());
            if (ctl[27]) begin
                held = result;
                @(negedge clk);
                check_vec("R10 random hold", result, held);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule